// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Receiver

This block turns a single NRZ serial line into received characters. A frame opens with one low start bit. The data bits follow, least significant bit first, and a high stop bit closes the frame. Timing comes from a clock-enable input that pulses sixteen times per bit period. The receiver qualifies the start bit at its middle and then samples every later bit at its middle.

Two frame formats are supported. Normal mode carries 7 or 8 data bits, with an optional even or odd parity bit. Multiprocessor mode always carries 8 data bits. A ninth bit then marks the character as an address or as data; this bit takes the place of parity and is presented beside the data. Each completed frame is loaded into a holding register together with its parity and framing status. A receive-full flag follows, and it can raise an interrupt. A read strobe consumes the character. A frame that arrives while the previous one is still unread is dropped and reported as an overrun.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then the extra bit if the format has one, then a stop bit. Each bit lasts 16 `os_tick_i` pulses, and the receiver samples each bit near its middle.
- R2: In normal mode (`mp_mode_i`=0), `len7_i`=1 selects 7 data bits, and `data_o[7]` then reads 0. `len7_i`=0 selects 8 data bits.
- R3: In normal mode with `par_en_i`=1, a parity bit follows the data. `perr_o` is set when the number of ones across the data and parity bits is odd while `par_odd_i`=0, or even while `par_odd_i`=1. With `par_en_i`=0, `perr_o` stays 0.
- R4: In multiprocessor mode (`mp_mode_i`=1), 8 data bits are followed by an address/data bit, and `adbit_o` presents it. No parity bit is checked, so `perr_o` stays 0. In normal mode `adbit_o` reads 0.
- R5: While `rx_en_i`=0 no frame is received, and the line has no effect on any output.
- R6: A start bit that is back high when sampled at its middle is ignored. The receiver returns to idle and accepts the next valid frame.
- R7: If the stop bit is sampled low, `ferr_o` is set and `full_o` is still raised. After any frame, the line must be seen high before a new start bit is accepted.
- R8: The error flags of a frame take their final values at least one cycle before `full_o` rises for that frame.
- R9: A one-cycle `rd_i` pulse while `full_o`=1 clears `full_o`, `perr_o`, `ferr_o` and `oerr_o` on the next cycle. `rd_i` while `full_o`=0 has no effect.
- R10: A frame that completes while `full_o`=1 and `rd_i`=0 sets `oerr_o`. That frame is discarded, and `data_o`, `adbit_o`, `perr_o` and `ferr_o` keep the earlier frame's values.
- R11: `irq_o` is 1 exactly when `full_o`=1 and `rie_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_i | input | 1 | Serial input line (asynchronous) |
| rx_en_i | input | 1 | Receiver enable |
| mp_mode_i | input | 1 | 1 = multiprocessor format |
| len7_i | input | 1 | 1 = 7 data bits (normal mode only) |
| par_en_i | input | 1 | 1 = parity bit present (normal mode only) |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rd_i | input | 1 | Read strobe, consumes the held character |
| rie_i | input | 1 | Receive-interrupt enable |
| data_o | output | 8 | Held character |
| adbit_o | output | 1 | Held address/data bit |
| full_o | output | 1 | Held character not yet read |
| perr_o | output | 1 | Parity error of the held character |
| ferr_o | output | 1 | Framing error of the held character |
| oerr_o | output | 1 | A frame was lost while the held character was unread |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach from the ports is a frame completing while the previous character is still unread. The bench sends two frames back to back without a read strobe. It then checks that the overrun flag is set and that the first frame's data, address bit and error flags are untouched. A second hard case is the false start: the bench drives a short low pulse that is over before the mid-bit sample. It checks that nothing is posted and that the frame immediately after is received intact. The sweep steps every byte value through rotating formats, with injected parity faults and alternating interrupt enable.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/mp_uart_rx_sync.sv
module mp_uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mp_uart_rx_framer.sv
module mp_uart_rx_framer
  import mp_uart_rx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  logic              mp_i,
  input  logic              len7_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              extra_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic              extra_q, par_q, armed_q;
  logic              done_q, perr_q, ferr_q;
  logic [IDX_W-1:0]  dlen, last_idx;

  // data length and index of the final bit before stop
  always_comb begin
    dlen     = (mp_i || !len7_i) ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    last_idx = (mp_i || par_en_i) ? dlen : dlen - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      extra_q <= 1'b0;
      par_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        armed_q <= 1'b0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            armed_q <= rx_i;
            if (armed_q && !rx_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (rx_i) begin
                state_q <= ST_IDLE;  // glitch
                armed_q <= 1'b0;
              end else begin
                state_q <= ST_BITS;
                idx_q   <= '0;
                data_q  <= '0;
                extra_q <= 1'b0;
                par_q   <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BITS: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              par_q <= par_q ^ rx_i;
              if (idx_q < dlen) begin
                for (int b = 0; b < DATA_W; b++)
                  if (idx_q == IDX_W'(b)) data_q[b] <= rx_i;
              end else begin
                extra_q <= rx_i;
              end
              idx_q <= idx_q + 1'b1;
              if (idx_q == last_idx) state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              done_q  <= 1'b1;
              ferr_q  <= !rx_i;
              perr_q  <= par_en_i && !mp_i && (par_q != par_odd_i);
              state_q <= ST_IDLE;
              armed_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign data_o  = data_q;
  assign extra_o = extra_q && mp_i;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/mp_uart_rx_hold.sv
module mp_uart_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              extra_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  input  logic              rie_i,
  output logic [DATA_W-1:0] data_o,
  output logic              extra_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              oerr_o,
  output logic              irq_o,
  output logic              post_o
);
  logic [DATA_W-1:0] data_q;
  logic extra_q, full_q, perr_q, ferr_q, oerr_q, post_q;
  logic consume, accept;

  assign consume = rd_i && full_q;
  assign accept  = !full_q || rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      extra_q <= 1'b0;
      full_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      oerr_q  <= 1'b0;
      post_q  <= 1'b0;
    end else begin
      post_q <= done_i && accept;
      // status lands one cycle ahead of the full flag
      if (post_q)       full_q <= 1'b1;
      else if (consume) full_q <= 1'b0;
      if (done_i && accept) begin
        data_q  <= data_i;
        extra_q <= extra_i;
        perr_q  <= perr_i;
        ferr_q  <= ferr_i;
        oerr_q  <= 1'b0;
      end else if (done_i) begin
        oerr_q <= 1'b1;
      end else if (consume) begin
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        oerr_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign extra_o = extra_q;
  assign full_o  = full_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
  assign oerr_o  = oerr_q;
  assign irq_o   = full_q && rie_i;
  assign post_o  = post_q;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              mp_mode_i,
  input  logic              len7_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  input  logic              rie_i,
  output logic [DATA_W-1:0] data_o,
  output logic              adbit_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              oerr_o,
  output logic              irq_o
);
  logic              rx_s;
  logic              frame_done, f_extra, f_perr, f_ferr, frame_post;
  logic [DATA_W-1:0] f_data;

  mp_uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  mp_uart_rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) i_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (os_tick_i),
    .rx_i     (rx_s),
    .en_i     (rx_en_i),
    .mp_i     (mp_mode_i),
    .len7_i   (len7_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .done_o   (frame_done),
    .data_o   (f_data),
    .extra_o  (f_extra),
    .perr_o   (f_perr),
    .ferr_o   (f_ferr)
  );

  mp_uart_rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (frame_done),
    .data_i (f_data),
    .extra_i(f_extra),
    .perr_i (f_perr),
    .ferr_i (f_ferr),
    .rd_i   (rd_i),
    .rie_i  (rie_i),
    .data_o (data_o),
    .extra_o(adbit_o),
    .full_o (full_o),
    .perr_o (perr_o),
    .ferr_o (ferr_o),
    .oerr_o (oerr_o),
    .irq_o  (irq_o),
    .post_o (frame_post)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic              rie_i,
  input logic              full_o,
  input logic              perr_o,
  input logic              ferr_o,
  input logic              oerr_o,
  input logic              irq_o,
  input logic              adbit_o,
  input logic [DATA_W-1:0] data_o,
  input logic              frame_done
);
  a_r8_flags_before_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $stable(perr_o) && $stable(ferr_o));

  a_r8_full_follows_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(frame_done, 2));

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && full_o) |=> !full_o && !perr_o && !ferr_o && !oerr_o);

  a_r10_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && full_o && !rd_i) |=> oerr_o);

  a_r10_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> $stable(data_o) && $stable(adbit_o));

  a_r5_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !frame_done);

  a_r11_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rie_i || !full_o) |-> !irq_o);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .rd_i      (rd_i),
  .rie_i     (rie_i),
  .full_o    (full_o),
  .perr_o    (perr_o),
  .ferr_o    (ferr_o),
  .oerr_o    (oerr_o),
  .irq_o     (irq_o),
  .adbit_o   (adbit_o),
  .data_o    (data_o),
  .frame_done(frame_done)
);

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, rx = 1'b1, rx_en = 1'b1, mp = 1'b0, len7 = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, rd = 1'b0, rie = 1'b0;
  logic [7:0] data;
  logic adbit, full, perr, ferr, oerr, irq;

  int errors = 0, checks = 0, tick_div = 1, tick_cnt = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
  end
  assign tick = (tick_cnt == 0);

  mp_uart_rx i_mp_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx), .rx_en_i(rx_en),
    .mp_mode_i(mp), .len7_i(len7), .par_en_i(par_en), .par_odd_i(par_odd),
    .rd_i(rd), .rie_i(rie), .data_o(data), .adbit_o(adbit), .full_o(full),
    .perr_o(perr), .ferr_o(ferr), .oerr_o(oerr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8: flags must already be stable in the sample before full rises
  logic prev_full = 1'b0, prev_perr = 1'b0, prev_ferr = 1'b0;
  always @(negedge clk) begin
    if (rst_n && full && !prev_full) begin
      chk("R8 perr settled", {31'd0, perr}, {31'd0, prev_perr});
      chk("R8 ferr settled", {31'd0, ferr}, {31'd0, prev_ferr});
    end
    prev_full <= full;
    prev_perr <= perr;
    prev_ferr <= ferr;
  end

  task automatic hold_bit(input logic lvl);
    rx = lvl;
    repeat (OSR * tick_div) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] payload, input int n, input logic stop_lvl);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) hold_bit(payload[i]);
    hold_bit(stop_lvl);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
    chk("R9 full cleared", {31'd0, full}, 32'd0);
    chk("R9 errors cleared", {29'd0, perr, ferr, oerr}, 32'd0);
  endtask

  // md: 0 8b even, 1 8b odd, 2 7b none, 3 multiproc, 4 7b even
  task automatic run_frame(input logic [7:0] d, input int md, input logic ad,
                           input logic bad_par, input logic stop_lvl, input logic do_rd);
    logic [8:0] pl;
    int n;
    logic [7:0] exp_d;
    logic pbit;
    mp = (md == 3);
    len7 = (md == 2 || md == 4);
    par_en = (md == 0 || md == 1 || md == 4);
    par_odd = (md == 1);
    exp_d = len7 ? {1'b0, d[6:0]} : d;
    pbit = (^exp_d) ^ par_odd ^ bad_par;
    if (md == 3) begin
      pl = {ad, d}; n = 9;
    end else if (len7) begin
      pl = {1'b0, pbit, d[6:0]}; n = par_en ? 8 : 7;
    end else begin
      pl = {pbit, d}; n = par_en ? 9 : 8;
    end
    send(pl, n, stop_lvl);
    chk("R1 full raised", {31'd0, full}, 32'd1);
    chk("R1 R2 data", {24'd0, data}, {24'd0, exp_d});
    chk("R4 adbit", {31'd0, adbit}, {31'd0, (md == 3) ? ad : 1'b0});
    chk("R3 perr", {31'd0, perr}, {31'd0, par_en && bad_par});
    chk("R7 ferr", {31'd0, ferr}, {31'd0, !stop_lvl});
    chk("R11 irq", {31'd0, irq}, {31'd0, rie});
    if (do_rd) do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset full", {31'd0, full}, 32'd0);
    chk("reset flags", {28'd0, perr, ferr, oerr, irq}, 32'd0);
    chk("reset data", {23'd0, adbit, data}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4 R11 sweep over every byte with rotating formats
    for (int v = 0; v < 256; v++) begin
      rie = v[1];
      run_frame(v[7:0], v % 5, v[4], (v % 7 == 0) && (v % 5 != 2) && (v % 5 != 3), 1'b1, 1'b1);
    end

    // R1 with a slower tick
    tick_div = 3;
    run_frame(8'hA5, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_frame(8'h3C, 3, 1'b1, 1'b0, 1'b1, 1'b1);
    tick_div = 1;

    // R7 framing error, then a clean frame
    run_frame(8'h5A, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame(8'hC3, 1, 1'b0, 1'b0, 1'b1, 1'b1);

    // R9 read with nothing held has no effect
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    chk("R9 idle read", {28'd0, full, perr, ferr, oerr}, 32'd0);

    // R5 disabled receiver
    rx_en = 1'b0;
    mp = 1'b0; len7 = 1'b0; par_en = 1'b0;
    send(9'h0F0, 8, 1'b1);
    chk("R5 no frame when disabled", {31'd0, full}, 32'd0);
    chk("R5 data untouched", {24'd0, data}, 32'hC3);
    rx_en = 1'b1;
    repeat (4 * OSR) @(negedge clk);

    // R6 false start, then a valid frame
    @(negedge clk);
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (3 * OSR) @(negedge clk);
    chk("R6 glitch ignored", {31'd0, full}, 32'd0);
    chk("R6 glitch no error", {29'd0, perr, ferr, oerr}, 32'd0);
    run_frame(8'h81, 2, 1'b0, 1'b0, 1'b1, 1'b1);

    // R10 overrun: second frame lost, first kept
    rie = 1'b1;
    run_frame(8'h12, 4, 1'b0, 1'b1, 1'b1, 1'b0);
    mp = 1'b1; len7 = 1'b0; par_en = 1'b0;
    send({1'b1, 8'hEE}, 9, 1'b1);
    chk("R10 oerr set", {31'd0, oerr}, 32'd1);
    chk("R10 data kept", {24'd0, data}, 32'h12);
    chk("R10 adbit kept", {31'd0, adbit}, 32'd0);
    chk("R10 perr kept", {31'd0, perr}, 32'd1);
    chk("R10 full held", {31'd0, full}, 32'd1);
    chk("R11 irq held", {31'd0, irq}, 32'd1);
    do_read();
    rie = 1'b0;
    run_frame(8'h77, 3, 1'b1, 1'b0, 1'b1, 1'b1);

    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule